// File: doc/BRIEF.md
# Serial Flash Page Program Buffer

This block sits behind the serial interface decoder of a NOR flash with 256-byte pages. At the start of a program transaction it captures a 24-bit start address. It then assembles the incoming data bits into bytes. Each strobe brings one bit on a single wire or two bits on a pair of wires, and the first bit received is the most significant. Each finished byte goes into a page-sized staging buffer. The low address byte is used as a pointer that wraps inside the page, so a long stream keeps only its most recent 256 bytes.

When chip select rises, the decoder raises a commit strobe. The commit is accepted only when all of these hold: the write-enable latch is set, the protection logic allows the page, at least one byte arrived, and no partial byte is pending. An accepted commit starts a program cycle that stays busy for a fixed, parameterized number of clocks. During the first 256 cycles of the busy window, the buffer is drained to the array as write requests, one per staged byte, in ascending offset order. Each request carries a clear mask, so the array can only turn ones into zeros. When the busy window ends, the write-enable latch is cleared.

Top module: `pp_program_buffer`

## Requirements
- R1: After reset, busy_o, wel_o and wr_vld_o are all 0.
- R2: With dual_i=0, each bit_vld_i strobe shifts in dq_i[0], most significant bit first. The bytes land at consecutive page offsets, starting at addr_i[7:0] as captured by start_i.
- R3: With dual_i=1, each strobe shifts in two bits, with dq_i[1] as the more significant bit. The bytes land in the buffer exactly as in R2.
- R4: The offset wraps from FFh to 00h. wr_addr_o[23:8] stays equal to the captured addr_i[23:8] for every write request of the cycle.
- R5: When more than 256 bytes are sent, each offset keeps the last byte written to it.
- R6: Only offsets that received a byte are written. Requests come one per cycle in ascending offset order, and only while busy_o is 1.
- R7: A commit is rejected when the number of bits received is not a multiple of 8. A rejected commit produces no busy and no write request.
- R8: A commit is rejected when wel_o is 0 or allow_i is 0.
- R9: An accepted commit raises busy_o on the next cycle for exactly PROG_CYCLES cycles. wel_o stays 1 while busy and falls together with busy_o.
- R10: While busy, start_i, bit_vld_i, wel_set_i and commit_i are ignored. A commit received later without a new start_i is rejected.
- R11: wr_clr_o is the bitwise inverse of the staged byte, where a 1 means clear that bit. A staged FFh byte produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wel_set_i | input | 1 | Set the write-enable latch |
| allow_i | input | 1 | Protection check passed for the addressed page |
| start_i | input | 1 | Begin a transaction; captures addr_i |
| addr_i | input | 24 | Start address |
| bit_vld_i | input | 1 | Data bit strobe |
| dual_i | input | 1 | 1: two bits per strobe |
| dq_i | input | 2 | Data bits; dq_i[0] is used alone in single-wire mode |
| commit_i | input | 1 | Chip select rose |
| busy_o | output | 1 | Program cycle in progress |
| wel_o | output | 1 | Write-enable latch |
| wr_vld_o | output | 1 | Array write request |
| wr_addr_o | output | 24 | Byte address of the request |
| wr_clr_o | output | 8 | Bits to clear at that byte |

## Verification
The assertions assume several things about the decoder. It never raises commit_i in the same cycle as a bit strobe, or in the cycle after one. dual_i stays constant within a transaction. start_i and commit_i are never high together. The directed tasks change inputs only on falling edges. They hold each strobe for one cycle and leave idle cycles between strobes. They wait two idle cycles before each commit. The one deliberate breach of the idle rule happens inside the busy window, where R10 requires every input to be ignored.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pp_bit_asm.sv
module pp_bit_asm
  import pp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       bit_vld_i,
  input  logic       dual_i,
  input  logic [1:0] dq_i,
  output logic       byte_vld_o,
  output byte_t      byte_o,
  output logic       aligned_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  byte_t            sh_q, sh_nxt;
  logic             vld_q, done;

  always_comb begin
    sh_nxt  = dual_i ? {sh_q[BYTE_W-3:0], dq_i} : {sh_q[BYTE_W-2:0], dq_i[0]};
    cnt_nxt = cnt_q + (dual_i ? CNT_W'(2) : CNT_W'(1));
    done    = (cnt_nxt >= CNT_W'(BYTE_W));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (bit_vld_i) begin
        sh_q  <= sh_nxt;
        cnt_q <= done ? '0 : cnt_nxt;
        vld_q <= done;
      end
    end
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = sh_q;
  assign aligned_o  = (cnt_q == '0) && !vld_q;

  // R2: a byte only completes on a bit strobe
  p_byte_from_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(bit_vld_i));
endmodule

// File: rtl/pp_page_buf.sv
module pp_page_buf
  import pp_pkg::*;
#(
  parameter int unsigned PAGE_W = 8,
  localparam int unsigned PAGE_N = 1 << PAGE_W,
  localparam int unsigned HI_W   = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              wr_i,
  input  byte_t             data_i,
  input  logic              flush_i,
  output logic              any_o,
  output logic              wr_vld_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output byte_t             wr_clr_o
);
  byte_t             clr_q [PAGE_N];
  logic [PAGE_N-1:0] valid_q;
  logic [PAGE_W-1:0] ptr_q, idx_q;
  logic [HI_W-1:0]   page_q;
  logic              flushing_q;

  always_ff @(posedge clk_i) begin
    if (wr_i && !load_i) clr_q[ptr_q] <= ~data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ptr_q   <= '0;
      page_q  <= '0;
    end else if (load_i) begin
      valid_q <= '0;
      ptr_q   <= base_i[PAGE_W-1:0];
      page_q  <= base_i[ADDR_W-1:PAGE_W];
    end else if (wr_i) begin
      valid_q[ptr_q] <= 1'b1;
      ptr_q          <= ptr_q + 1'b1;  // wraps inside the page
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flushing_q <= 1'b0;
      idx_q      <= '0;
    end else if (flush_i) begin
      flushing_q <= 1'b1;
      idx_q      <= '0;
    end else if (flushing_q) begin
      if (idx_q == PAGE_W'(PAGE_N - 1)) flushing_q <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign any_o     = |valid_q;
  assign wr_vld_o  = flushing_q && valid_q[idx_q] && (clr_q[idx_q] != '0);
  assign wr_addr_o = {page_q, idx_q};
  assign wr_clr_o  = clr_q[idx_q];
endmodule

// File: rtl/pp_busy_tmr.sv
module pp_busy_tmr #(
  parameter int unsigned PROG_CYCLES = 300,
  localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CNT_W'(PROG_CYCLES - 1));
endmodule

// File: rtl/pp_program_buffer.sv
module pp_program_buffer
  import pp_pkg::*;
#(
  parameter int unsigned PAGE_W      = 8,
  parameter int unsigned PROG_CYCLES = 300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wel_set_i,
  input  logic              allow_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bit_vld_i,
  input  logic              dual_i,
  input  logic [1:0]        dq_i,
  input  logic              commit_i,
  output logic              busy_o,
  output logic              wel_o,
  output logic              wr_vld_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_clr_o
);
  logic  active_q, wel_q, load, accept, done;
  logic  byte_vld, aligned, any;
  byte_t byte_d;

  assign load   = start_i && !busy_o;
  assign accept = commit_i && !busy_o && !start_i && active_q && aligned &&
                  wel_q && allow_i && any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wel_q    <= 1'b0;
    end else begin
      if (load)                       active_q <= 1'b1;
      else if (commit_i && !busy_o)   active_q <= 1'b0;
      if (done)                       wel_q <= 1'b0;
      else if (wel_set_i && !busy_o)  wel_q <= 1'b1;
    end
  end

  pp_bit_asm i_asm (
    .clk_i, .rst_ni,
    .clr_i      (load),
    .bit_vld_i  (bit_vld_i && active_q && !busy_o),
    .dual_i, .dq_i,
    .byte_vld_o (byte_vld),
    .byte_o     (byte_d),
    .aligned_o  (aligned)
  );

  pp_page_buf #(.PAGE_W(PAGE_W)) i_buf (
    .clk_i, .rst_ni,
    .load_i    (load),
    .base_i    (addr_i),
    .wr_i      (byte_vld),
    .data_i    (byte_d),
    .flush_i   (accept),
    .any_o     (any),
    .wr_vld_o, .wr_addr_o, .wr_clr_o
  );

  pp_busy_tmr #(.PROG_CYCLES(PROG_CYCLES)) i_tmr (
    .clk_i, .rst_ni,
    .start_i (accept),
    .busy_o,
    .done_o  (done)
  );

  assign wel_o = wel_q;

  p_wel_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> wel_o);
  p_busy_from_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(commit_i));
  p_wr_in_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |-> busy_o);
  p_page_fixed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_o && $past(wr_vld_o)) |->
      (wr_addr_o[ADDR_W-1:PAGE_W] == $past(wr_addr_o[ADDR_W-1:PAGE_W])));
  p_clr_nonzero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |-> (wr_clr_o != '0));
endmodule

// File: tb/test_pp_program_buffer.sv
module test_pp_program_buffer;
  localparam int PROG = 300;

  logic clk = 0, rst_n = 0;
  logic wel_set = 0, allow = 0, start = 0, bit_vld = 0, dual = 0, commit = 0;
  logic [23:0] addr = '0;
  logic [1:0]  dq = '0;
  logic busy, wel, wr_vld;
  logic [23:0] wr_addr;
  logic [7:0]  wr_clr;

  int checks = 0, errs = 0;
  logic [7:0]  exp_clr [256];
  bit          exp_w   [256];
  logic [7:0]  got_clr [256];
  bit          got_w   [256];
  logic [15:0] exp_page;
  logic [7:0]  ptr;
  int busy_cnt, wr_total, order_bad, page_bad;

  always #2 clk = ~clk;

  pp_program_buffer #(.PAGE_W(8), .PROG_CYCLES(PROG)) i_pp_program_buffer (
    .clk_i(clk), .rst_ni(rst_n), .wel_set_i(wel_set), .allow_i(allow),
    .start_i(start), .addr_i(addr), .bit_vld_i(bit_vld), .dual_i(dual),
    .dq_i(dq), .commit_i(commit), .busy_o(busy), .wel_o(wel),
    .wr_vld_o(wr_vld), .wr_addr_o(wr_addr), .wr_clr_o(wr_clr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_wel();
    @(negedge clk) wel_set = 1;
    @(negedge clk) wel_set = 0;
  endtask

  task automatic begin_tx(input logic [23:0] a, input bit d);
    for (int i = 0; i < 256; i++) begin exp_w[i] = 0; exp_clr[i] = '0; end
    exp_page = a[23:8];
    ptr = a[7:0];
    dual = d;
    @(negedge clk) begin start = 1; addr = a; end
    @(negedge clk) start = 0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i = i - (dual ? 2 : 1)) begin
      @(negedge clk) begin
        bit_vld = 1;
        dq = dual ? {b[i], b[i-1]} : {1'b0, b[i]};
      end
      @(negedge clk) bit_vld = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
    exp_w[ptr]   = (b != 8'hFF);
    exp_clr[ptr] = ~b;
    ptr++;
  endtask

  // commit, then watch the busy window; inject drives all inputs mid-window
  task automatic commit_collect(input bit inject);
    int last_off;
    for (int i = 0; i < 256; i++) begin got_w[i] = 0; got_clr[i] = '0; end
    busy_cnt = 0; wr_total = 0; order_bad = 0; page_bad = 0; last_off = -1;
    @(negedge clk); @(negedge clk);
    @(negedge clk) commit = 1;
    @(negedge clk) commit = 0;
    for (int c = 0; c < PROG + 10; c++) begin
      if (busy) busy_cnt++;
      if (wr_vld) begin
        wr_total++;
        if (int'(wr_addr[7:0]) <= last_off) order_bad++;
        if (wr_addr[23:8] != exp_page) page_bad++;
        last_off = int'(wr_addr[7:0]);
        got_w[wr_addr[7:0]] = 1;
        got_clr[wr_addr[7:0]] = wr_clr;
      end
      if (inject && c == 10) begin
        wel_set = 1; start = 1; addr = 24'hFFFFFF; bit_vld = 1; dq = 2'b11; commit = 1;
      end else if (inject && c == 11) begin
        wel_set = 0; start = 0; bit_vld = 0; commit = 0;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_writes(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++)
      if (got_w[i] != exp_w[i] || (exp_w[i] && got_clr[i] != exp_clr[i])) bad++;
    chk(bad == 0, {req, " write set/masks"}, bad, 0);
    chk(order_bad == 0, "R6 ascending order", order_bad, 0);
    chk(page_bad == 0, "R4 page fixed", page_bad, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0, "R1 busy", busy, 0);
    chk(wel == 0, "R1 wel", wel, 0);
    chk(wr_vld == 0, "R1 wr_vld", wr_vld, 0);
  endtask

  task automatic t_single();
    set_wel(); allow = 1;
    chk(wel == 1, "R9 wel set", wel, 1);
    begin_tx(24'h123440, 0);
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'hFF); send_byte(8'h00);
    commit_collect(0);
    check_writes("R2");
    chk(got_clr[8'h40] == 8'h5A, "R2 first byte mask", got_clr[8'h40], 8'h5A);
    chk(!got_w[8'h42], "R11 FFh byte no request", got_w[8'h42], 0);
    chk(got_clr[8'h43] == 8'hFF, "R11 00h clears all", got_clr[8'h43], 8'hFF);
    chk(wr_total == 3, "R6 write count", wr_total, 3);
    chk(busy_cnt == PROG, "R9 busy length", busy_cnt, PROG);
    chk(wel == 0, "R9 wel cleared", wel, 0);
  endtask

  task automatic t_dual();
    set_wel();
    begin_tx(24'h0ABC10, 1);
    send_byte(8'h81); send_byte(8'h7E); send_byte(8'hC6);
    commit_collect(0);
    check_writes("R3");
    chk(got_clr[8'h12] == 8'h39, "R3 dual bit order", got_clr[8'h12], 8'h39);
  endtask

  task automatic t_wrap();
    set_wel();
    begin_tx(24'h4321FE, 0);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    commit_collect(0);
    check_writes("R4");
    chk(got_w[0] && got_clr[0] == 8'hCC, "R4 wrap to 00h", got_clr[0], 8'hCC);
  endtask

  task automatic t_over();
    set_wel();
    begin_tx(24'h055500, 1);
    for (int j = 0; j < 258; j++) send_byte(j < 256 ? 8'h0F : 8'hF0);
    commit_collect(0);
    check_writes("R5");
    chk(got_clr[1] == 8'h0F, "R5 last byte wins", got_clr[1], 8'h0F);
    chk(got_clr[2] == 8'hF0, "R5 older byte kept", got_clr[2], 8'hF0);
    chk(wr_total == 256, "R5 full page", wr_total, 256);
  endtask

  task automatic t_partial();
    set_wel();
    begin_tx(24'h000100, 0);
    send_byte(8'h55); send_bits(8'hA0, 3);
    commit_collect(0);
    chk(busy_cnt == 0, "R7 partial byte no busy", busy_cnt, 0);
    chk(wr_total == 0, "R7 partial byte no write", wr_total, 0);
    chk(wel == 1, "R7 wel kept", wel, 1);
  endtask

  task automatic t_protect();
    allow = 0;
    begin_tx(24'h000200, 0);
    send_byte(8'h12);
    commit_collect(0);
    chk(busy_cnt == 0 && wr_total == 0, "R8 allow=0 rejected", busy_cnt, 0);
    allow = 1;
    @(negedge clk) begin wel_set = 0; end
    begin_tx(24'h000300, 0);
    send_byte(8'h12);
    commit_collect(0);
    // wel still 1 here from before; now run one accepted cycle to clear it
    chk(busy_cnt == PROG, "R8 allow=1 accepted", busy_cnt, PROG);
    begin_tx(24'h000400, 0);
    send_byte(8'h12);
    commit_collect(0);
    chk(busy_cnt == 0 && wr_total == 0, "R8 wel=0 rejected", busy_cnt, 0);
  endtask

  task automatic t_busy_ignore();
    set_wel();
    begin_tx(24'h777780, 0);
    send_byte(8'hF3);
    commit_collect(1);
    check_writes("R10");
    chk(busy_cnt == PROG, "R10 busy not extended", busy_cnt, PROG);
    chk(wel == 0, "R10 wel_set ignored", wel, 0);
    set_wel();
    commit_collect(0);
    chk(busy_cnt == 0 && wr_total == 0, "R10 no session after busy", busy_cnt, 0);
  endtask

  initial begin
    #(4 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_dual();
    t_wrap();
    t_over();
    t_partial();
    t_protect();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule